// File: doc/BRIEF.md
# Hall-Sensor Commutation Decoder for Brushless DC Motors

This block turns three Hall position-sensor bits into six enables for a three-phase half-bridge. The enables are three upper switches and three lower switches. A two-bit spacing select tells the decoder which six-code Hall cycle the motor produces. The supported sensor spacings are 60, 120, 240 and 300 electrical degrees. A direction input picks which bridge pair is energised for each step, and any code outside the selected cycle shuts the bridge off. The sensor, spacing and direction inputs pass through a two-flop synchronizer before decoding.

Two control pins act at once, without the synchronizer delay. A brake input shorts the windings by turning on every lower switch. It does this whatever the other inputs are, reset included. A drive-permit input blanks the whole bridge when it is low; PWM and overcurrent logic outside the block drive it. A build parameter inverts the upper enables to suit P-channel gate drivers. A second build parameter turns the decoder into a four-phase commutator. In that mode it reads two sensors, with the second sensor wired to both S2 and S3, and drives one winding switch at a time.

Top module: `hall_commutator`

## Requirements
- R1: While rst_n is low, and for the first two rising clock edges after it rises, all drivers are off (drv_lo = 000 and upper switches off) unless brake is high.
- R2: Encoding: hall_i[2]=S1, hall_i[1]=S2, hall_i[0]=S3. drv_hi[0..2] drive upper switches O1..O3 and drv_lo[0..2] drive lower switches O4..O6. With dir_fwd=1, the six positions of each spacing cycle enable, in order, O1+O5, O3+O5, O3+O4, O2+O4, O2+O6, O1+O6. The cycles in S1S2S3 order are: spacing_sel=00: 000,100,110,111,011,001. spacing_sel=01: 001,101,100,110,010,011. spacing_sel=10: 010,110,100,101,001,011. spacing_sel=11: 011,111,110,100,000,001.
- R3: With dir_fwd=0, position k of the cycle enables the pair that forward operation gives to position (k+3) mod 6.
- R4: Codes outside the selected cycle turn every driver off. These are 010 and 101 for spacing 00 and 11, and 000 and 111 for spacing 01 and 10.
- R5: brake=1 forces all upper switches off and all three lower switches on, in the same cycle. It overrides permit, sensor code and reset.
- R6: drive_ok=0 with brake=0 turns every driver off in the same cycle. Returning it high restores the decoded pair in the same cycle.
- R7: A change on hall_i, spacing_sel or dir_fwd reaches the outputs after exactly two rising clock edges.
- R8: With FOUR_PHASE=1, the code {S1,S2} (S2=S3) steps 00,10,11,01. It enables O1, O3, O4, O6 one at a time with dir_fwd=1, and O4, O6, O1, O3 with dir_fwd=0.
- R9: With FOUR_PHASE=1, a code with S2 different from S3, or any spacing_sel other than 00, turns every driver off.
- R10: With UPPER_ACTIVE_LOW=1, drv_hi is the bitwise inverse of the active-high upper enables (1 = off). drv_lo polarity is unchanged.
- R11: With brake low, at most one upper and at most one lower switch are on, and never the two switches of the same leg. In three-phase mode an upper switch is on exactly when a lower switch is on. In four-phase mode at most one switch is on in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_i | input | 3 | Hall sensor bits {S1,S2,S3} |
| spacing_sel | input | 2 | Sensor spacing select (00=60°, 01=120°, 10=240°, 11=300°) |
| dir_fwd | input | 1 | 1 = forward, 0 = reverse |
| brake | input | 1 | Dynamic brake, highest priority |
| drive_ok | input | 1 | Bridge permit from PWM/overcurrent gating |
| drv_hi | output | 3 | Upper switch enables O1..O3 |
| drv_lo | output | 3 | Lower switch enables O4..O6 (active high) |

## Verification
The bench builds two instances side by side. The first uses the defaults, three-phase with active-high upper enables. It walks all four spacing tables in both directions, every illegal code and the two-edge latency. The second is built with FOUR_PHASE=1 and UPPER_ACTIVE_LOW=1. It exercises the four-step winding sequence and its illegal codes. It also shows the inverted upper polarity, including during braking, where every upper output must read 1.

// File: rtl/hall_pkg.sv
package hall_pkg;
  localparam int unsigned LEGS       = 3;
  localparam int unsigned STEPS_3PH  = 6;
  localparam int unsigned STEPS_4PH  = 4;
  localparam int unsigned STEP_W     = $clog2(STEPS_3PH);
  localparam int unsigned HALF_3PH   = STEPS_3PH / 2;
  localparam int unsigned HALF_4PH   = STEPS_4PH / 2;

  typedef logic [LEGS-1:0]   leg_t;
  typedef logic [STEP_W-1:0] step_idx_t;

  typedef struct packed {
    logic      ok;
    step_idx_t idx;
  } step_t;
endpackage

// File: rtl/hall_sync.sv
module hall_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hall_step_decode.sv
module hall_step_decode
  import hall_pkg::*;
#(
  parameter bit FOUR_PHASE = 1'b0
) (
  input  logic [2:0] code,
  input  logic [1:0] sel,
  output step_t      step
);
  if (FOUR_PHASE) begin : g_four
    always_comb begin
      step = '0;
      if (sel == 2'b00 && code[1] == code[0]) begin
        step.ok = 1'b1;
        unique case ({code[2], code[1]})
          2'b00:   step.idx = step_idx_t'(0);
          2'b10:   step.idx = step_idx_t'(1);
          2'b11:   step.idx = step_idx_t'(2);
          default: step.idx = step_idx_t'(3);
        endcase
      end
    end
  end else begin : g_three
    always_comb begin
      step = '{ok: 1'b1, idx: '0};
      case (sel)
        2'b00: case (code)
          3'b000: step.idx = step_idx_t'(0);
          3'b100: step.idx = step_idx_t'(1);
          3'b110: step.idx = step_idx_t'(2);
          3'b111: step.idx = step_idx_t'(3);
          3'b011: step.idx = step_idx_t'(4);
          3'b001: step.idx = step_idx_t'(5);
          default: step.ok = 1'b0;
        endcase
        2'b01: case (code)
          3'b001: step.idx = step_idx_t'(0);
          3'b101: step.idx = step_idx_t'(1);
          3'b100: step.idx = step_idx_t'(2);
          3'b110: step.idx = step_idx_t'(3);
          3'b010: step.idx = step_idx_t'(4);
          3'b011: step.idx = step_idx_t'(5);
          default: step.ok = 1'b0;
        endcase
        2'b10: case (code)
          3'b010: step.idx = step_idx_t'(0);
          3'b110: step.idx = step_idx_t'(1);
          3'b100: step.idx = step_idx_t'(2);
          3'b101: step.idx = step_idx_t'(3);
          3'b001: step.idx = step_idx_t'(4);
          3'b011: step.idx = step_idx_t'(5);
          default: step.ok = 1'b0;
        endcase
        default: case (code)
          3'b011: step.idx = step_idx_t'(0);
          3'b111: step.idx = step_idx_t'(1);
          3'b110: step.idx = step_idx_t'(2);
          3'b100: step.idx = step_idx_t'(3);
          3'b000: step.idx = step_idx_t'(4);
          3'b001: step.idx = step_idx_t'(5);
          default: step.ok = 1'b0;
        endcase
      endcase
    end
  end
endmodule

// File: rtl/hall_drive_encode.sv
module hall_drive_encode
  import hall_pkg::*;
#(
  parameter bit FOUR_PHASE = 1'b0
) (
  input  step_idx_t idx,
  input  logic      dir_fwd,
  output leg_t      hi_en,
  output leg_t      lo_en
);
  step_idx_t eff;

  if (FOUR_PHASE) begin : g_four
    always_comb begin
      eff   = dir_fwd ? idx : step_idx_t'((idx + step_idx_t'(HALF_4PH)) % STEPS_4PH);
      hi_en = '0;
      lo_en = '0;
      case (eff)
        step_idx_t'(0): hi_en = 3'b001;
        step_idx_t'(1): hi_en = 3'b100;
        step_idx_t'(2): lo_en = 3'b001;
        default:        lo_en = 3'b100;
      endcase
    end
  end else begin : g_three
    always_comb begin
      if (dir_fwd)                         eff = idx;
      else if (idx < step_idx_t'(HALF_3PH)) eff = idx + step_idx_t'(HALF_3PH);
      else                                 eff = idx - step_idx_t'(HALF_3PH);
      case (eff)
        step_idx_t'(0): begin hi_en = 3'b001; lo_en = 3'b010; end
        step_idx_t'(1): begin hi_en = 3'b100; lo_en = 3'b010; end
        step_idx_t'(2): begin hi_en = 3'b100; lo_en = 3'b001; end
        step_idx_t'(3): begin hi_en = 3'b010; lo_en = 3'b001; end
        step_idx_t'(4): begin hi_en = 3'b010; lo_en = 3'b100; end
        step_idx_t'(5): begin hi_en = 3'b001; lo_en = 3'b100; end
        default:        begin hi_en = 3'b000; lo_en = 3'b000; end
      endcase
    end
  end
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hall_pkg::*;
#(
  parameter bit          UPPER_ACTIVE_LOW = 1'b0,
  parameter bit          FOUR_PHASE       = 1'b0,
  parameter int unsigned SYNC_STAGES      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_i,
  input  logic [1:0] spacing_sel,
  input  logic       dir_fwd,
  input  logic       brake,
  input  logic       drive_ok,
  output logic [2:0] drv_hi,
  output logic [2:0] drv_lo
);
  localparam int unsigned  IN_W     = 6;
  localparam logic [IN_W-1:0] IN_RST = {3'b000, 2'b00, 1'b1};

  logic [IN_W-1:0] in_q;
  logic            run_q;
  step_t           step;
  leg_t            enc_hi, enc_lo;
  leg_t            hi_act, lo_act;

  hall_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_in_sync (
    .clk(clk), .rst_n(rst_n),
    .d({hall_i, spacing_sel, dir_fwd}),
    .q(in_q)
  );

  hall_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_run_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(run_q)
  );

  hall_step_decode #(.FOUR_PHASE(FOUR_PHASE)) u_decode (
    .code(in_q[5:3]), .sel(in_q[2:1]), .step(step)
  );

  hall_drive_encode #(.FOUR_PHASE(FOUR_PHASE)) u_encode (
    .idx(step.idx), .dir_fwd(in_q[0]), .hi_en(enc_hi), .lo_en(enc_lo)
  );

  always_comb begin
    hi_act = '0;
    lo_act = '0;
    if (brake) begin
      lo_act = '1;
    end else if (run_q && drive_ok && step.ok) begin
      hi_act = enc_hi;
      lo_act = enc_lo;
    end
  end

  if (UPPER_ACTIVE_LOW) begin : g_hi_inv
    assign drv_hi = ~hi_act;
  end else begin : g_hi_true
    assign drv_hi = hi_act;
  end
  assign drv_lo = lo_act;
endmodule

// File: rtl/hall_commutator_chk.sv
module hall_commutator_chk #(
  parameter bit UPPER_ACTIVE_LOW = 1'b0,
  parameter bit FOUR_PHASE       = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       brake,
  input logic       drive_ok,
  input logic [2:0] drv_hi,
  input logic [2:0] drv_lo
);
  logic [2:0] hi_on;
  assign hi_on = drv_hi ^ {3{UPPER_ACTIVE_LOW}};

  // R1
  always @(posedge clk) begin
    if (!rst_n && !brake)
      reset_quiet_chk: assert (hi_on == 3'b000 && drv_lo == 3'b000)
        else $error("drivers active during reset");
  end

  // R1
  startup_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && !brake) |-> (hi_on == 3'b000 && drv_lo == 3'b000));

  // R5
  brake_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brake |-> (hi_on == 3'b000 && drv_lo == 3'b111));

  // R6
  permit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!brake && !drive_ok) |-> (hi_on == 3'b000 && drv_lo == 3'b000));

  // R11
  no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !brake |-> ((hi_on & drv_lo) == 3'b000 && $onehot0(hi_on) && $onehot0(drv_lo)));

  // R11
  pair_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !brake |-> (FOUR_PHASE ? ($countones({hi_on, drv_lo}) <= 1)
                           : ($countones(hi_on) == $countones(drv_lo))));
endmodule

bind hall_commutator hall_commutator_chk #(
  .UPPER_ACTIVE_LOW(UPPER_ACTIVE_LOW),
  .FOUR_PHASE(FOUR_PHASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .brake(brake), .drive_ok(drive_ok),
  .drv_hi(drv_hi), .drv_lo(drv_lo)
);

// File: tb/hall_commutator_tb_top.sv
module hall_commutator_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hall = 3'b000;
  logic [1:0] sel = 2'b00;
  logic       dir_fwd = 1'b1;
  logic       brake = 1'b0;
  logic       drive_ok = 1'b1;
  logic [2:0] hi3, lo3, hi4, lo4;
  int         vectors = 0;
  int         fails = 0;

  localparam logic [2:0] CYC [4][6] = '{
    '{3'b000, 3'b100, 3'b110, 3'b111, 3'b011, 3'b001},
    '{3'b001, 3'b101, 3'b100, 3'b110, 3'b010, 3'b011},
    '{3'b010, 3'b110, 3'b100, 3'b101, 3'b001, 3'b011},
    '{3'b011, 3'b111, 3'b110, 3'b100, 3'b000, 3'b001}};
  localparam logic [2:0] BAD [4][2] = '{
    '{3'b010, 3'b101}, '{3'b000, 3'b111}, '{3'b000, 3'b111}, '{3'b010, 3'b101}};
  // forward pairs O1+O5, O3+O5, O3+O4, O2+O4, O2+O6, O1+O6
  localparam logic [2:0] FHI [6] = '{3'b001, 3'b100, 3'b100, 3'b010, 3'b010, 3'b001};
  localparam logic [2:0] FLO [6] = '{3'b010, 3'b010, 3'b001, 3'b001, 3'b100, 3'b100};
  // four-phase: sensor codes and forward winding order O1, O3, O4, O6
  localparam logic [2:0] CYC4 [4] = '{3'b000, 3'b100, 3'b111, 3'b011};
  localparam logic [5:0] F4 [4] = '{6'b001_000, 6'b100_000, 6'b000_001, 6'b000_100};

  always #2 clk = ~clk;

  hall_commutator dut_i (
    .clk(clk), .rst_n(rst_n), .hall_i(hall), .spacing_sel(sel), .dir_fwd(dir_fwd),
    .brake(brake), .drive_ok(drive_ok), .drv_hi(hi3), .drv_lo(lo3));

  hall_commutator #(.UPPER_ACTIVE_LOW(1'b1), .FOUR_PHASE(1'b1)) dut4_i (
    .clk(clk), .rst_n(rst_n), .hall_i(hall), .spacing_sel(sel), .dir_fwd(dir_fwd),
    .brake(brake), .drive_ok(drive_ok), .drv_hi(hi4), .drv_lo(lo4));

  task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [2:0] h, input logic [1:0] s, input logic d);
    @(negedge clk);
    hall = h; sel = s; dir_fwd = d;
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 0; hall = 3'b000; sel = 2'b00; dir_fwd = 1; brake = 0; drive_ok = 1;
    repeat (3) @(negedge clk);
    check("R1 in reset", {hi3, lo3}, 6'b000_000);
    rst_n = 1;
    @(negedge clk);
    check("R1 first edge after reset", {hi3, lo3}, 6'b000_000);
    @(negedge clk);
    check("R2 enabled after blanking", {hi3, lo3}, {FHI[0], FLO[0]});
  endtask

  task automatic t_forward;
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 6; k++) begin
        apply(CYC[s][k], 2'(s), 1'b1);
        check($sformatf("R2 sel%0d pos%0d", s, k), {hi3, lo3}, {FHI[k], FLO[k]});
        check("R11 one upper one lower",
              {4'b0, 1'($countones(hi3) == 1), 1'($countones(lo3) == 1)}, 6'b000_011);
      end
  endtask

  task automatic t_reverse;
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 6; k++) begin
        apply(CYC[s][k], 2'(s), 1'b0);
        check($sformatf("R3 sel%0d pos%0d", s, k), {hi3, lo3},
              {FHI[(k + 3) % 6], FLO[(k + 3) % 6]});
      end
  endtask

  task automatic t_illegal;
    for (int s = 0; s < 4; s++)
      for (int b = 0; b < 2; b++) begin
        apply(BAD[s][b], 2'(s), 1'b1);
        check($sformatf("R4 sel%0d code %b", s, BAD[s][b]), {hi3, lo3}, 6'b000_000);
      end
  endtask

  task automatic t_latency;
    apply(CYC[1][0], 2'b01, 1'b1);
    @(negedge clk);
    hall = CYC[1][1];
    @(posedge clk); @(negedge clk);
    check("R7 one edge keeps old pair", {hi3, lo3}, {FHI[0], FLO[0]});
    @(posedge clk); @(negedge clk);
    check("R7 two edges give new pair", {hi3, lo3}, {FHI[1], FLO[1]});
    dir_fwd = 0;
    @(posedge clk); @(negedge clk);
    check("R7 direction one edge", {hi3, lo3}, {FHI[1], FLO[1]});
    @(posedge clk); @(negedge clk);
    check("R7 direction two edges", {hi3, lo3}, {FHI[4], FLO[4]});
  endtask

  task automatic t_brake;
    apply(CYC[0][2], 2'b00, 1'b1);
    brake = 1; #1;
    check("R5 brake immediate", {hi3, lo3}, 6'b000_111);
    drive_ok = 0; #1;
    check("R5 brake over permit", {hi3, lo3}, 6'b000_111);
    apply(BAD[0][0], 2'b00, 1'b1);
    check("R5 brake over illegal", {hi3, lo3}, 6'b000_111);
    brake = 0; drive_ok = 1;
    apply(CYC[0][2], 2'b00, 1'b1);
    check("R5 release restores", {hi3, lo3}, {FHI[2], FLO[2]});
  endtask

  task automatic t_permit;
    apply(CYC[3][4], 2'b11, 1'b1);
    drive_ok = 0; #1;
    check("R6 permit low off", {hi3, lo3}, 6'b000_000);
    @(posedge clk); @(negedge clk);
    check("R6 permit low held", {hi3, lo3}, 6'b000_000);
    drive_ok = 1; #1;
    check("R6 permit restore", {hi3, lo3}, {FHI[4], FLO[4]});
  endtask

  task automatic t_four;
    for (int k = 0; k < 4; k++) begin
      apply(CYC4[k], 2'b00, 1'b1);
      check($sformatf("R8 fwd step%0d", k), {~hi4, lo4}, F4[k]);
      check("R10 upper inverted", {hi4, lo4}, {~F4[k][5:3], F4[k][2:0]});
    end
    for (int k = 0; k < 4; k++) begin
      apply(CYC4[k], 2'b00, 1'b0);
      check($sformatf("R8 rev step%0d", k), {~hi4, lo4}, F4[(k + 2) % 4]);
    end
    apply(3'b001, 2'b00, 1'b1);
    check("R9 S2!=S3 off", {hi4, lo4}, 6'b111_000);
    apply(3'b110, 2'b00, 1'b1);
    check("R9 S2!=S3 off", {hi4, lo4}, 6'b111_000);
    apply(3'b000, 2'b01, 1'b1);
    check("R9 nonzero select off", {hi4, lo4}, 6'b111_000);
    brake = 1; #1;
    check("R10 brake inverted upper", {hi4, lo4}, 6'b111_111);
    brake = 0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_forward();
    t_reverse();
    t_illegal();
    t_latency();
    t_brake();
    t_permit();
    t_four();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule